// File: doc/BRIEF.md
# Serial Converter Host Sequencer

This block sits on the host side of a four-wire serial link to a self-calibrating sign-magnitude analog-to-digital converter. It drives chip select, a serial clock and an instruction line. It reads the converter's data line and watches an end-of-conversion flag. One command runs a whole start-up routine: a calibration instruction, then status polls until calibration finishes. Other commands send one conversion instruction or one configuration instruction and return what the converter shifted out during that exchange.

Every exchange on the link carries as many serial clocks as the output word the converter is currently set to produce. That length is chosen by an earlier instruction. The sequencer therefore tracks it, so the link stays aligned even when chip select is never released. The data returned by an exchange always belongs to the conversion started by the previous conversion instruction, so each response carries that earlier tag. The instruction byte values for calibration and status are parameters. Conversion and configuration bytes are supplied with each command.

Top module: `adc_host_seq`

## Requirements
- R1: After reset, `adc_cs_n` is high, `adc_sclk` is low, and `busy` and `rsp_valid` are low. The first exchange uses 13 serial clocks.
- R2: Each exchange uses a number of serial clocks equal to the word length. The base length is 8, 12 or 16 for length code 0, 1 or 2 (code 3 counts as 16), plus one when the sign bit is enabled.
- R3: The length of an exchange is the one set by the most recent earlier conversion or configuration command, never the one carried by the command in flight. A conversion command sets both the length code and the sign; a configuration command sets only the sign.
- R4: Command kind 0 first sends `OP_CAL` and discards the word received. It then sends `OP_STATUS` and discards the first word received. It keeps sending `OP_STATUS` until a received word has bit `CAL_BIT` low, and returns that word with `rsp_conv` low.
- R5: A configuration command (kind 2 or 3) starts no conversion. Its response carries the data of the last conversion and that conversion's tag.
- R6: A conversion command (kind 1) returns the word received during its own exchange. `rsp_tag` is the tag of the previous conversion command, and `rsp_conv` is high only if a conversion command preceded since the last start-up routine.
- R7: After a conversion exchange, no further serial clock edge and no falling edge of chip select occurs until `adc_eoc` is high.
- R8: When `cs_hold` is low at command accept, chip select rises after every exchange. When it is high, chip select stays low between exchanges.
- R9: The instruction byte is shifted out MSB first and changes after falling clock edges. The bits after the first eight are zero. The data line is sampled on rising edges, and the received word is returned right-aligned in `rsp_data`.
- R10: Each serial clock half period lasts `DIV` system clocks.
- R11: `busy` is high from command accept until the cycle `rsp_valid` pulses. A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_kind | input | 2 | 0 start-up, 1 conversion, 2/3 configuration |
| cmd_code | input | 8 | Instruction byte for conversion or configuration |
| cmd_len | input | 2 | Length code chosen by a conversion command |
| cmd_sign | input | 1 | Sign enable chosen by conversion or configuration |
| cmd_tag | input | TAG_W | Tag of this command |
| cs_hold | input | 1 | Keep chip select low between exchanges |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_data | output | 17 | Received word, right-aligned |
| rsp_tag | output | TAG_W | Tag of the conversion the data belongs to |
| rsp_conv | output | 1 | Data comes from a conversion |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_di | output | 1 | Instruction line to the converter |
| adc_do | input | 1 | Data line from the converter |
| adc_eoc | input | 1 | Converter idle (conversion finished) |

## Verification
The bench runs a converter model that counts clocks by word length alone. A sequencer that used the new command's length, or forgot the sign bit, would fall out of step, and with chip select held low the returned data would come back scrambled. The model's first status word after calibration has the calibration bit low, so a sequencer that trusted that read would stop one poll early and return the wrong status. Sign-only configuration steps placed between conversions expose responses that carry the wrong tag or start a conversion. Clocking the converter while end-of-conversion is low, and commands injected while busy, show up as counted violations and as extra exchanges.

// File: rtl/adc_host_seq.sv
module adc_host_seq #(
  parameter int         DIV     = 4,
  parameter int         TAG_W   = 4,
  parameter logic [7:0] OP_CAL    = 8'h20,
  parameter logic [7:0] OP_STATUS = 8'h30,
  parameter int         CAL_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [7:0]       cmd_code,
  input  logic [1:0]       cmd_len,
  input  logic             cmd_sign,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic             cs_hold,
  output logic             busy,
  output logic             rsp_valid,
  output logic [16:0]      rsp_data,
  output logic [TAG_W-1:0] rsp_tag,
  output logic             rsp_conv,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_di,
  input  logic             adc_do,
  input  logic             adc_eoc
);
  localparam int WW = 17;
  localparam int DW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [1:0] K_INIT = 2'd0;
  localparam logic [1:0] K_CONV = 2'd1;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_WAIT = 2'd1, S_XFER = 2'd2, S_GAP = 2'd3} st_t;

  st_t              st;
  logic [DW-1:0]    div_cnt;
  logic [1:0]       kind, nlen, len_code, step;
  logic             nsign, sign, hold_r, done, conv_pend, have_conv;
  logic [TAG_W-1:0] tag_r, last_tag;
  logic [WW-1:0]    sh_out, sh_in, word;
  logic [4:0]       bit_cnt, base, nbits;
  logic             tick;

  assign tick  = (div_cnt == DW'(DIV - 1));
  assign base  = (len_code == 2'd0) ? 5'd8 : (len_code == 2'd1) ? 5'd12 : 5'd16;
  assign nbits = base + {4'd0, sign};
  assign word  = sh_in & ((WW'(1) << nbits) - WW'(1));
  assign busy  = (st != S_IDLE);
  assign adc_di = (st == S_XFER) & sh_out[WW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      div_cnt   <= '0;
      kind      <= K_INIT;
      nlen      <= 2'd1;
      nsign     <= 1'b1;
      len_code  <= 2'd1;
      sign      <= 1'b1;
      step      <= 2'd0;
      hold_r    <= 1'b0;
      done      <= 1'b0;
      conv_pend <= 1'b0;
      have_conv <= 1'b0;
      tag_r     <= '0;
      last_tag  <= '0;
      sh_out    <= '0;
      sh_in     <= '0;
      bit_cnt   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= '0;
      rsp_conv  <= 1'b0;
      adc_cs_n  <= 1'b1;
      adc_sclk  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (st == S_XFER || st == S_GAP) div_cnt <= tick ? '0 : div_cnt + 1'b1;
      else                             div_cnt <= '0;

      case (st)
        S_IDLE: if (cmd_valid) begin
          kind   <= cmd_kind;
          tag_r  <= cmd_tag;
          nlen   <= cmd_len;
          nsign  <= cmd_sign;
          hold_r <= cs_hold;
          step   <= 2'd0;
          done   <= 1'b0;
          sh_out <= {(cmd_kind == K_INIT) ? OP_CAL : cmd_code, 9'd0};
          if (!cs_hold) adc_cs_n <= 1'b1;
          st     <= S_WAIT;
        end

        S_WAIT: if (!conv_pend || adc_eoc) begin
          st        <= S_XFER;
          adc_cs_n  <= 1'b0;
          conv_pend <= 1'b0;
          bit_cnt   <= '0;
          adc_sclk  <= 1'b0;
        end

        S_XFER: if (tick) begin
          if (!adc_sclk) begin
            adc_sclk <= 1'b1;
            sh_in    <= {sh_in[WW-2:0], adc_do};
          end else begin
            adc_sclk <= 1'b0;
            sh_out   <= sh_out << 1;
            bit_cnt  <= bit_cnt + 5'd1;
            if (bit_cnt == nbits - 5'd1) begin
              st       <= S_GAP;
              adc_cs_n <= !hold_r;
              if (kind == K_INIT) begin
                have_conv <= 1'b0;
                sh_out    <= {OP_STATUS, 9'd0};
                if (step != 2'd2) step <= step + 2'd1;
                else if (!word[CAL_BIT]) begin
                  done     <= 1'b1;
                  rsp_data <= word;
                  rsp_conv <= 1'b0;
                  rsp_tag  <= last_tag;
                end
              end else begin
                done     <= 1'b1;
                rsp_data <= word;
                rsp_conv <= have_conv;
                rsp_tag  <= last_tag;
                sign     <= nsign;
                if (kind == K_CONV) begin
                  len_code  <= nlen;
                  last_tag  <= tag_r;
                  have_conv <= 1'b1;
                  conv_pend <= 1'b1;
                end
              end
            end
          end
        end

        S_GAP: if (tick) begin
          if (done) begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
          end else begin
            st <= S_WAIT;
          end
        end

        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_host_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       busy,
  input logic       rsp_valid,
  input logic       cs_n,
  input logic       sclk,
  input logic       di,
  input logic       eoc,
  input logic [1:0] st,
  input logic       conv_pend,
  input logic       hold_r,
  input logic [4:0] nbits
);
  p_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nbits inside {5'd8, 5'd9, 5'd12, 5'd13, 5'd16, 5'd17});

  p_eoc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && conv_pend && !eoc) |=> (st != 2'd2));

  p_clock_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && hold_r) |-> !cs_n);

  p_di_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !di);

  p_busy_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy)));

  p_accept_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && st == 2'd2) |=> busy);
endmodule

bind adc_host_seq adc_host_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .rsp_valid(rsp_valid), .cs_n(adc_cs_n), .sclk(adc_sclk), .di(adc_di),
  .eoc(adc_eoc), .st(st), .conv_pend(conv_pend), .hold_r(hold_r), .nbits(nbits)
);

// File: tb/test_adc_host_seq.sv
`timescale 1ns/1ps
module test_adc_host_seq;
  localparam int DIV = 4;
  localparam logic [7:0] OPC = 8'h20;
  localparam logic [7:0] OPS = 8'h30;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_sign = 0, cs_hold = 0;
  logic [1:0] cmd_kind = 0, cmd_len = 0;
  logic [7:0] cmd_code = 0;
  logic [3:0] cmd_tag = 0;
  logic busy, rsp_valid, rsp_conv, adc_cs_n, adc_sclk, adc_di, adc_do, adc_eoc;
  logic [16:0] rsp_data;
  logic [3:0] rsp_tag;

  always #4 clk = ~clk;

  adc_host_seq #(.DIV(DIV), .TAG_W(4), .OP_CAL(OPC), .OP_STATUS(OPS), .CAL_BIT(0)) i_adc_host_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_code(cmd_code),
    .cmd_len(cmd_len), .cmd_sign(cmd_sign), .cmd_tag(cmd_tag), .cs_hold(cs_hold), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag), .rsp_conv(rsp_conv),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_di(adc_di), .adc_do(adc_do), .adc_eoc(adc_eoc));

  int checks = 0, fails = 0;

  function automatic int flen(input logic [1:0] l, input logic s);
    return ((l == 2'd0) ? 8 : (l == 2'd1) ? 12 : 16) + int'(s);
  endfunction
  function automatic logic [16:0] lmask(input int n);
    return (n >= 17) ? 17'h1FFFF : 17'((64'd1 << n) - 1);
  endfunction

  // converter model
  int m_idx = 0, m_len = 13, m_rises = 0, m_viol = 0, m_viol2 = 0, m_di_bad = 0;
  int m_cal = 0, m_n = 0, m_req = 0, m_seen = 0, m_tmr = 0, m_xfers = 0, cs_rises = 0;
  logic [1:0] m_lcode = 2'd1;
  logic m_sign = 1'b1, m_eoc = 1'b1, cs_q = 1'b1, bit_o;
  logic [7:0] m_ish = 0, m_last_ins = 0;
  logic [16:0] m_raw = 17'h0AAAA, m_word;
  longint t_prev = 0, t_last = 0;

  assign m_word = m_raw & lmask(m_len);
  always_comb begin
    bit_o = 1'b0;
    if (m_idx < m_len) bit_o = m_word[m_len - 1 - m_idx];
  end
  assign adc_do  = bit_o;
  assign adc_eoc = m_eoc;

  always @(posedge adc_sclk or posedge adc_cs_n) begin
    logic [7:0] ins;
    logic [1:0] nl;
    logic ns;
    if (adc_cs_n) m_idx <= 0;
    else begin
      m_rises <= m_rises + 1;
      t_prev <= t_last;
      t_last <= $time;
      if (!m_eoc) m_viol <= m_viol + 1;
      if (m_idx < 8) m_ish <= {m_ish[6:0], adc_di};
      else if (adc_di) m_di_bad <= m_di_bad + 1;
      if (m_idx == m_len - 1) begin
        ins = (m_len == 8) ? {m_ish[6:0], adc_di} : m_ish;
        nl = m_lcode; ns = m_sign;
        m_idx <= 0;
        m_last_ins <= ins;
        m_xfers <= m_xfers + 1;
        if (ins == OPC) begin
          m_cal <= 3; m_raw <= 17'h0AAAA;
        end else if (ins == OPS) begin
          m_cal <= (m_cal > 0) ? m_cal - 1 : 0;
          m_raw <= 17'h00C00 | 17'((m_cal > 1) ? 1 : 0);
        end else if (ins[7]) begin
          nl = ins[5:4]; ns = ins[3];
          m_raw <= {ins, 8'(m_n), 1'b1};
          m_n <= m_n + 1;
          m_req <= m_req + 1;
        end else if (ins[7:4] == 4'h5) begin
          ns = ins[0];
        end
        m_lcode <= nl; m_sign <= ns;
        m_len <= flen(nl, ns);
      end else m_idx <= m_idx + 1;
    end
  end

  always @(posedge clk) begin
    cs_q <= adc_cs_n;
    if (cs_q && !adc_cs_n && !m_eoc) m_viol2 <= m_viol2 + 1;
    if (!cs_q && adc_cs_n) cs_rises <= cs_rises + 1;
    if (m_req != m_seen) begin
      m_seen <= m_req; m_eoc <= 1'b0; m_tmr <= 200;
    end else if (m_tmr > 0) begin
      m_tmr <= m_tmr - 1;
      if (m_tmr == 1) m_eoc <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench expectation state
  logic [16:0] e_raw = 0;
  int e_len = 13, e_n = 0;
  logic [1:0] e_lcode = 2'd1;
  logic e_sign = 1'b1, e_conv = 1'b0;
  logic [3:0] e_tag = 0;
  int r0, x0, c0;

  task automatic run_cmd(input logic [1:0] k, input logic [1:0] l, input logic s, input logic [2:0] ch,
                         input logic [3:0] tg, input logic hold, input bit poke);
    logic [7:0] code;
    code = (k == 2'd1) ? {2'b10, l, s, ch} : {4'h5, 3'd0, s};
    r0 = m_rises; x0 = m_xfers; c0 = cs_rises;
    @(negedge clk);
    cmd_kind = k; cmd_len = l; cmd_sign = s; cmd_code = code; cmd_tag = tg; cs_hold = hold; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(busy == 1'b1, "R11", "busy mid command", busy, 1);
      cmd_kind = 2'd0; cmd_valid = 1;
      repeat (5) @(negedge clk);
      cmd_valid = 0;
    end
    while (!rsp_valid) @(negedge clk);
  endtask

  localparam int NV = 8;
  // {exp_rises[4:0], kind[1:0], len[1:0], sign, chan[2:0], tag[3:0]}
  localparam logic [16:0] VEC [NV] = '{
    {5'd13, 2'd1, 2'd1, 1'b1, 3'd1, 4'd1},
    {5'd13, 2'd1, 2'd0, 1'b0, 3'd2, 4'd2},
    {5'd8,  2'd1, 2'd2, 1'b1, 3'd3, 4'd3},
    {5'd17, 2'd2, 2'd0, 1'b0, 3'd0, 4'd4},
    {5'd16, 2'd3, 2'd0, 1'b1, 3'd0, 4'd5},
    {5'd17, 2'd1, 2'd1, 1'b0, 3'd6, 4'd6},
    {5'd12, 2'd1, 2'd0, 1'b1, 3'd7, 4'd7},
    {5'd9,  2'd1, 2'd1, 1'b1, 3'd4, 4'd8}
  };

  task automatic check_rsp(input logic [1:0] k, input logic [1:0] l, input logic s, input logic [2:0] ch,
                           input logic [3:0] tg, input int exp_rises);
    logic [16:0] exp_d;
    exp_d = e_raw & lmask(e_len);
    chk(m_rises - r0 == exp_rises, "R2", "clock count", m_rises - r0, exp_rises);
    chk(m_rises - r0 == e_len, "R3", "length from earlier command", m_rises - r0, e_len);
    chk(rsp_data == exp_d, "R6", "returned word", rsp_data, exp_d);
    chk(rsp_conv == e_conv, "R6", "conversion flag", rsp_conv, e_conv);
    if (e_conv) chk(rsp_tag == e_tag, "R6", "tag of earlier conversion", rsp_tag, e_tag);
    if (k == 2'd1) begin
      chk(m_last_ins == {2'b10, l, s, ch}, "R9", "instruction byte", m_last_ins, {2'b10, l, s, ch});
      e_raw = {2'b10, l, s, ch, 8'(e_n), 1'b1};
      e_n++; e_lcode = l; e_sign = s; e_tag = tg; e_conv = 1'b1;
    end else begin
      chk(adc_eoc == 1'b1, "R5", "config starts no conversion", adc_eoc, 1);
      e_sign = s;
    end
    e_len = flen(e_lcode, e_sign);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1", "cs after reset", adc_cs_n, 1);
    chk(adc_sclk == 1'b0, "R1", "sclk after reset", adc_sclk, 0);
    chk(busy == 1'b0 && rsp_valid == 1'b0, "R1", "busy/valid after reset", {busy, rsp_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // start-up routine: cal, discarded status, three polls
    run_cmd(2'd0, 2'd0, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0);
    chk(m_rises - r0 == 65, "R1", "five 13-clock exchanges", m_rises - r0, 65);
    chk(m_xfers - x0 == 5, "R4", "exchange count", m_xfers - x0, 5);
    chk(rsp_data == 17'h00C00, "R4", "final status word", rsp_data, 17'h00C00);
    chk(rsp_conv == 1'b0, "R4", "status not a conversion", rsp_conv, 0);
    chk(cs_rises - c0 == 5, "R8", "strobed cs rises", cs_rises - c0, 5);
    e_raw = 17'h00C00; e_conv = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i][11:10], VEC[i][9:8], VEC[i][7], VEC[i][6:4], VEC[i][3:0], 1'b0, 1'b0);
      chk(cs_rises - c0 == 1, "R8", "one cs rise per exchange", cs_rises - c0, 1);
      check_rsp(VEC[i][11:10], VEC[i][9:8], VEC[i][7], VEC[i][6:4], VEC[i][3:0], int'(VEC[i][16:12]));
    end
    chk(t_last - t_prev == 2 * DIV * 8, "R10", "sclk period ns", t_last - t_prev, 2 * DIV * 8);

    // chip select held low
    run_cmd(2'd1, 2'd1, 1'b1, 3'd5, 4'd9, 1'b1, 1'b0);
    chk(cs_rises - c0 == 0 && adc_cs_n == 1'b0, "R8", "cs held low", cs_rises - c0, 0);
    check_rsp(2'd1, 2'd1, 1'b1, 3'd5, 4'd9, 13);
    run_cmd(2'd2, 2'd0, 1'b0, 3'd0, 4'd10, 1'b1, 1'b0);
    check_rsp(2'd2, 2'd0, 1'b0, 3'd0, 4'd10, 13);
    run_cmd(2'd1, 2'd2, 1'b1, 3'd1, 4'd11, 1'b1, 1'b0);
    chk(cs_rises - c0 == 0, "R8", "cs still low", cs_rises - c0, 0);
    check_rsp(2'd1, 2'd2, 1'b1, 3'd1, 4'd11, 12);

    // back to strobed, with a command injected while busy
    run_cmd(2'd1, 2'd1, 1'b1, 3'd2, 4'd12, 1'b0, 1'b1);
    check_rsp(2'd1, 2'd1, 1'b1, 3'd2, 4'd12, 17);
    chk(m_xfers - x0 == 1, "R11", "ignored command made no exchange", m_xfers - x0, 1);
    repeat (300) @(negedge clk);
    chk(busy == 1'b0 && m_xfers - x0 == 1, "R11", "still idle afterwards", m_xfers - x0, 1);

    chk(m_viol == 0, "R7", "clock edges during conversion", m_viol, 0);
    chk(m_viol2 == 0, "R7", "cs falls during conversion", m_viol2, 0);
    chk(m_di_bad == 0, "R9", "nonzero bits after instruction", m_di_bad, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule